// File: doc/BRIEF.md
# MDIO Management Register Slave

This block is the PHY-side end of the two-wire station management bus. It oversamples the management clock (`mdc`) and data (`mdio_i`) with the local system clock. It recognises frames that begin with a run of at least 32 ones, and it decodes the read or write opcode, the 5-bit PHY address and the 5-bit register index. It then serves a space of 32 registers, each 16 bits wide. Read data leaves on `mdio_o`, qualified by the tri-state enable `mdio_oe`.

The PHY address is taken from the strap inputs on the first clock after reset is released, and register 25 returns it. The slave answers both that address and address 0. The control register drives a set of control outputs. The status inputs, the partner-ability word and three externally kept event counters are visible through the status, partner and counter registers. The counters are reached through a small select/data read port.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: On a read frame addressed to this slave, `mdio_oe` stays low during the first turnaround bit, rises with `mdio_o` = 0 for the second turnaround bit, and then carries the 16 data bits MSB first, one per MDC rising edge.
- R2: Frames whose PHY address equals the strapped address or 00000 are served. Any other address produces no MDIO drive and no register change.
- R3: The strap inputs are captured on the first clock after reset release and held until the next reset. Register 25 bits 4:0 return them, and bit 6 returns the inverse of the speed-select bit.
- R4: When the captured address is 00000, the isolate output and register 0 bit 10 read 1 and cannot be cleared by a write.
- R5: Register 0 maps bit 14 loopback, bit 13 speed (1 = 100 Mb/s), bit 12 auto-negotiation enable, bit 11 power down, bit 10 isolate and bit 8 full duplex onto the matching control outputs. After reset it reads 0x3000, or 0x3400 when the strap is zero.
- R6: Writing register 0 with bit 15 set raises `ctl_reset` for exactly one clock, restores register 0 and register 4 to their reset values, and bit 15 reads 0 afterwards.
- R7: Writing register 0 with bit 9 set raises `ctl_an_restart` for exactly one clock, and bit 9 reads 0 afterwards.
- R8: Registers 7 to 17, 26 and 29 to 31 read 0 and ignore writes. The read-only register 25 also ignores writes.
- R9: Register 4 resets to 0x01E1, with selector bits 4:0 = 00001. Bits 12:10 always read 0, and every other bit is writable.
- R10: Register 1 returns capability bits 15:11 from a parameter (default 01111), bit 5 auto-negotiation done, bit 4 remote fault, bit 3 = 1, bit 2 link, bit 1 jabber and bit 0 = 1. Register 5 returns `lp_ability`.
- R11: Reads of registers 18, 19 and 21 return `cnt_rdata` while `cnt_sel` is 0, 1 and 2 respectively.
- R12: A frame is accepted only after at least 32 consecutive ones followed by start bits 01. A shorter preamble, or an opcode other than 10 (read) or 01 (write), discards the frame.
- R13: `mdio_oe` is released on the MDC rising edge that follows the last read data bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples MDC |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_addr | input | 5 | Address straps, captured after reset |
| mdc | input | 1 | Management clock from the station |
| mdio_i | input | 1 | Management data in |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Drive enable for `mdio_o` |
| stat_link | input | 1 | Link status |
| stat_an_done | input | 1 | Auto-negotiation complete |
| stat_rem_fault | input | 1 | Remote fault seen |
| stat_jabber | input | 1 | Jabber condition |
| lp_ability | input | 16 | Link partner ability word |
| cnt_sel | output | 2 | Counter select: 0 disconnect, 1 false carrier, 2 receive error, 3 none |
| cnt_rdata | input | 16 | Value of the selected counter |
| ctl_reset | output | 1 | One-clock reset request |
| ctl_loopback | output | 1 | Loopback enable |
| ctl_speed100 | output | 1 | Speed select, 1 = 100 Mb/s |
| ctl_an_en | output | 1 | Auto-negotiation enable |
| ctl_pwrdn | output | 1 | Power down |
| ctl_isolate | output | 1 | Isolate from the data interface |
| ctl_an_restart | output | 1 | One-clock auto-negotiation restart |
| ctl_fdx | output | 1 | Full duplex |

## Verification
An MDC rising edge reaches the sequencer after two synchroniser stages and one edge-detect stage. Each response bit therefore changes `mdio_o`/`mdio_oe` on the third system clock edge after the rise, and a completed write reaches the control outputs on the fourth. The bench holds each MDC phase for four system clocks and samples the MDIO outputs on the last clock of the low phase, just before the next rise, when the bit driven at the previous rise has settled. Control outputs and the one-clock pulses are observed only after a full idle bit following the write, and a per-clock monitor measures pulse lengths.

// File: rtl/mdio_slave_pkg.sv
package mdio_slave_pkg;

  typedef enum logic [2:0] {
    FS_PREAMBLE,
    FS_START,
    FS_OPCODE,
    FS_ADDR,
    FS_TURN,
    FS_DATA
  } frame_state_e;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;

  localparam logic [4:0] RA_CTRL     = 5'd0;
  localparam logic [4:0] RA_STAT     = 5'd1;
  localparam logic [4:0] RA_ID_HI    = 5'd2;
  localparam logic [4:0] RA_ID_LO    = 5'd3;
  localparam logic [4:0] RA_ADV      = 5'd4;
  localparam logic [4:0] RA_PARTNER  = 5'd5;
  localparam logic [4:0] RA_CNT_DISC = 5'd18;
  localparam logic [4:0] RA_CNT_FCAR = 5'd19;
  localparam logic [4:0] RA_CNT_RXER = 5'd21;
  localparam logic [4:0] RA_STRAP    = 5'd25;

  localparam logic [1:0] CSEL_DISC = 2'd0;
  localparam logic [1:0] CSEL_FCAR = 2'd1;
  localparam logic [1:0] CSEL_RXER = 2'd2;
  localparam logic [1:0] CSEL_NONE = 2'd3;

  typedef struct packed {
    logic loopback;
    logic speed100;
    logic an_en;
    logic pwrdn;
    logic isolate;
    logic fdx;
  } ctrl_t;

  function automatic logic is_reserved(input logic [4:0] a);
    return ((a >= 5'd7) && (a <= 5'd17)) || (a == 5'd26) || (a >= 5'd29);
  endfunction

endpackage

// File: rtl/mdio_bit_sync.sv
module mdio_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc,
  input  logic mdio_i,
  output logic bit_stb,
  output logic bit_val
);
  logic [STAGES:0]   mdc_sh_q;
  logic [STAGES-1:0] dat_sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_sh_q <= '0;
      dat_sh_q <= '1;
    end else begin
      mdc_sh_q <= {mdc_sh_q[STAGES-1:0], mdc};
      dat_sh_q <= {dat_sh_q[STAGES-2:0], mdio_i};
    end
  end

  assign bit_stb = mdc_sh_q[STAGES-1] & ~mdc_sh_q[STAGES];
  assign bit_val = dat_sh_q[STAGES-1];

endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_slave_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int DW      = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          bit_stb,
  input  logic          bit_val,
  input  logic [4:0]    my_addr,
  input  logic [DW-1:0] rd_data,
  output logic [4:0]    reg_addr,
  output logic          wr_en,
  output logic [DW-1:0] wr_data,
  output logic          mdio_o,
  output logic          mdio_oe
);
  localparam int PW = $clog2(PRE_LEN + 1);
  localparam int BW = $clog2(DW);
  localparam logic [PW-1:0] PRE_SAT  = PW'(PRE_LEN);
  localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

  frame_state_e  st_q, st_d;
  logic [PW-1:0] pc_q, pc_d;
  logic [BW-1:0] bc_q, bc_d;
  logic [DW-1:0] sh_q, sh_d, shifted;
  logic          rd_q, rd_d;
  logic          hit_q, hit_d;
  logic [4:0]    ra_q, ra_d;
  logic          o_q, o_d;
  logic          oe_q, oe_d;
  logic          wr_q, wr_d;
  logic [DW-1:0] wd_q, wd_d;

  assign shifted = {sh_q[DW-2:0], bit_val};

  always_comb begin
    st_d  = st_q;
    pc_d  = pc_q;
    bc_d  = bc_q;
    sh_d  = sh_q;
    rd_d  = rd_q;
    hit_d = hit_q;
    ra_d  = ra_q;
    o_d   = o_q;
    oe_d  = oe_q;
    wr_d  = 1'b0;
    wd_d  = wd_q;
    if (enable && bit_stb) begin
      unique case (st_q)
        FS_PREAMBLE: begin
          if (bit_val) begin
            if (pc_q != PRE_SAT) pc_d = pc_q + 1'b1;
          end else begin
            if (pc_q == PRE_SAT) st_d = FS_START;
            pc_d = '0;
          end
        end
        FS_START: begin
          if (bit_val) begin
            st_d = FS_OPCODE;
            bc_d = '0;
          end else begin
            st_d = FS_PREAMBLE;
          end
        end
        FS_OPCODE: begin
          sh_d = shifted;
          bc_d = bc_q + 1'b1;
          if (bc_q == BW'(1)) begin
            bc_d = '0;
            if (shifted[1:0] == OP_READ) begin
              rd_d = 1'b1;
              st_d = FS_ADDR;
            end else if (shifted[1:0] == OP_WRITE) begin
              rd_d = 1'b0;
              st_d = FS_ADDR;
            end else begin
              st_d = FS_PREAMBLE;
            end
          end
        end
        FS_ADDR: begin
          sh_d = shifted;
          bc_d = bc_q + 1'b1;
          if (bc_q == BW'(9)) begin
            bc_d  = '0;
            hit_d = (shifted[9:5] == 5'd0) || (shifted[9:5] == my_addr);
            ra_d  = shifted[4:0];
            st_d  = FS_TURN;
          end
        end
        FS_TURN: begin
          bc_d = bc_q + 1'b1;
          if (bc_q == '0) begin
            if (rd_q && hit_q) begin
              oe_d = 1'b1;
              o_d  = 1'b0;
            end
            sh_d = rd_data;
          end else begin
            st_d = FS_DATA;
            bc_d = '0;
            o_d  = sh_q[DW-1];
            sh_d = {sh_q[DW-2:0], 1'b0};
          end
        end
        FS_DATA: begin
          bc_d = bc_q + 1'b1;
          if (rd_q) begin
            o_d  = sh_q[DW-1];
            sh_d = {sh_q[DW-2:0], 1'b0};
          end else begin
            sh_d = shifted;
          end
          if (bc_q == LAST_BIT) begin
            st_d = FS_PREAMBLE;
            pc_d = '0;
            oe_d = 1'b0;
            o_d  = 1'b0;
            if (!rd_q && hit_q) begin
              wr_d = 1'b1;
              wd_d = shifted;
            end
          end
        end
        default: st_d = FS_PREAMBLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FS_PREAMBLE;
      pc_q  <= '0;
      bc_q  <= '0;
      sh_q  <= '0;
      rd_q  <= 1'b0;
      hit_q <= 1'b0;
      ra_q  <= '0;
      o_q   <= 1'b0;
      oe_q  <= 1'b0;
      wr_q  <= 1'b0;
      wd_q  <= '0;
    end else begin
      st_q  <= st_d;
      pc_q  <= pc_d;
      bc_q  <= bc_d;
      sh_q  <= sh_d;
      rd_q  <= rd_d;
      hit_q <= hit_d;
      ra_q  <= ra_d;
      o_q   <= o_d;
      oe_q  <= oe_d;
      wr_q  <= wr_d;
      wd_q  <= wd_d;
    end
  end

  assign reg_addr = ra_q;
  assign wr_en    = wr_q;
  assign wr_data  = wd_q;
  assign mdio_o   = o_q;
  assign mdio_oe  = oe_q;

  // R13: the drive enable only exists inside the turnaround/data window
  p_oe_window_r13: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> (st_q == FS_TURN || st_q == FS_DATA));

  // R1: the first driven bit is the zero turnaround bit
  p_ta_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o);

  // R2: a write strobe is only produced for an addressed, non-read frame
  p_wr_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (hit_q && !rd_q && st_q == FS_PREAMBLE));

endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
  import mdio_slave_pkg::*;
#(
  parameter int          DW       = 16,
  parameter logic [31:0] PHY_ID   = 32'h0A0B_0C01,
  parameter logic [4:0]  CAPS     = 5'b01111,
  parameter logic [15:0] ADV_INIT = 16'h01E1,
  parameter logic [15:0] ADV_WMSK = 16'hE3FF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    strap_addr,
  input  logic [4:0]    reg_addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic [4:0]    my_addr,
  output logic          ready,
  input  logic          stat_link,
  input  logic          stat_an_done,
  input  logic          stat_rem_fault,
  input  logic          stat_jabber,
  input  logic [DW-1:0] lp_ability,
  output logic [1:0]    cnt_sel,
  input  logic [DW-1:0] cnt_rdata,
  output logic          ctl_reset,
  output logic          ctl_loopback,
  output logic          ctl_speed100,
  output logic          ctl_an_en,
  output logic          ctl_pwrdn,
  output logic          ctl_isolate,
  output logic          ctl_an_restart,
  output logic          ctl_fdx
);
  ctrl_t         ctl_q, ctl_d;
  logic [DW-1:0] adv_q, adv_d;
  logic [4:0]    addr_q, addr_d;
  logic          init_q, init_d;
  logic          rstp_q, rstp_d;
  logic          rsan_q, rsan_d;
  logic          addr_zero;
  logic          iso_eff;

  assign addr_zero = init_q && (addr_q == 5'd0);
  assign iso_eff   = ctl_q.isolate | addr_zero;

  always_comb begin
    ctl_d  = ctl_q;
    adv_d  = adv_q;
    addr_d = addr_q;
    init_d = init_q;
    rstp_d = 1'b0;
    rsan_d = 1'b0;
    if (!init_q) begin
      init_d        = 1'b1;
      addr_d        = strap_addr;
      ctl_d.isolate = (strap_addr == 5'd0);
    end else if (wr_en) begin
      if (reg_addr == RA_CTRL) begin
        if (wr_data[15]) begin
          rstp_d = 1'b1;
          ctl_d  = '{loopback: 1'b0, speed100: 1'b1, an_en: 1'b1,
                     pwrdn: 1'b0, isolate: (addr_q == 5'd0), fdx: 1'b0};
          adv_d  = ADV_INIT;
        end else begin
          ctl_d.loopback = wr_data[14];
          ctl_d.speed100 = wr_data[13];
          ctl_d.an_en    = wr_data[12];
          ctl_d.pwrdn    = wr_data[11];
          ctl_d.isolate  = wr_data[10];
          ctl_d.fdx      = wr_data[8];
          rsan_d         = wr_data[9];
        end
      end else if (reg_addr == RA_ADV) begin
        adv_d = wr_data & ADV_WMSK;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '{loopback: 1'b0, speed100: 1'b1, an_en: 1'b1,
                  pwrdn: 1'b0, isolate: 1'b0, fdx: 1'b0};
      adv_q  <= ADV_INIT;
      addr_q <= '0;
      init_q <= 1'b0;
      rstp_q <= 1'b0;
      rsan_q <= 1'b0;
    end else begin
      ctl_q  <= ctl_d;
      adv_q  <= adv_d;
      addr_q <= addr_d;
      init_q <= init_d;
      rstp_q <= rstp_d;
      rsan_q <= rsan_d;
    end
  end

  always_comb begin
    unique case (reg_addr)
      RA_CNT_DISC: cnt_sel = CSEL_DISC;
      RA_CNT_FCAR: cnt_sel = CSEL_FCAR;
      RA_CNT_RXER: cnt_sel = CSEL_RXER;
      default:     cnt_sel = CSEL_NONE;
    endcase
  end

  always_comb begin
    rd_data = '0;
    unique case (reg_addr)
      RA_CTRL:     rd_data = {rstp_q, ctl_q.loopback, ctl_q.speed100, ctl_q.an_en,
                              ctl_q.pwrdn, iso_eff, rsan_q, ctl_q.fdx, 8'h00};
      RA_STAT:     rd_data = {CAPS, 5'b00000, stat_an_done, stat_rem_fault, 1'b1,
                              stat_link, stat_jabber, 1'b1};
      RA_ID_HI:    rd_data = PHY_ID[31:16];
      RA_ID_LO:    rd_data = PHY_ID[15:0];
      RA_ADV:      rd_data = adv_q;
      RA_PARTNER:  rd_data = lp_ability;
      RA_CNT_DISC,
      RA_CNT_FCAR,
      RA_CNT_RXER: rd_data = cnt_rdata;
      RA_STRAP:    rd_data = {9'd0, ~ctl_q.speed100, 1'b0, addr_q};
      default:     rd_data = '0;
    endcase
  end

  assign my_addr        = addr_q;
  assign ready          = init_q;
  assign ctl_reset      = rstp_q;
  assign ctl_an_restart = rsan_q;
  assign ctl_loopback   = ctl_q.loopback;
  assign ctl_speed100   = ctl_q.speed100;
  assign ctl_an_en      = ctl_q.an_en;
  assign ctl_pwrdn      = ctl_q.pwrdn;
  assign ctl_isolate    = iso_eff;
  assign ctl_fdx        = ctl_q.fdx;

  // R6: reset request lasts a single clock
  p_reset_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_reset |=> !ctl_reset);

  // R7: restart request lasts a single clock
  p_restart_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_an_restart |=> !ctl_an_restart);

  // R4: zero strap keeps the block isolated
  p_iso_forced_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && my_addr == 5'd0) |-> ctl_isolate);

  // R3: captured address never moves once taken
  p_strap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(ready)) |-> $stable(my_addr));

  // R8: writes to reserved indices leave stored state untouched
  p_rsvd_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && wr_en && is_reserved(reg_addr)) |=> ($stable(adv_q) && $stable(ctl_q)));

endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
  import mdio_slave_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int          PRE_LEN     = 32,
  parameter logic [31:0] PHY_ID      = 32'h0A0B_0C01,
  parameter logic [4:0]  CAPS        = 5'b01111
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  strap_addr,
  input  logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        stat_link,
  input  logic        stat_an_done,
  input  logic        stat_rem_fault,
  input  logic        stat_jabber,
  input  logic [15:0] lp_ability,
  output logic [1:0]  cnt_sel,
  input  logic [15:0] cnt_rdata,
  output logic        ctl_reset,
  output logic        ctl_loopback,
  output logic        ctl_speed100,
  output logic        ctl_an_en,
  output logic        ctl_pwrdn,
  output logic        ctl_isolate,
  output logic        ctl_an_restart,
  output logic        ctl_fdx
);
  localparam int DW = 16;

  logic          bit_stb;
  logic          bit_val;
  logic [4:0]    reg_addr;
  logic          wr_en;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rd_data;
  logic [4:0]    my_addr;
  logic          ready;

  mdio_bit_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .mdc     (mdc),
    .mdio_i  (mdio_i),
    .bit_stb (bit_stb),
    .bit_val (bit_val)
  );

  mdio_frame #(.PRE_LEN(PRE_LEN), .DW(DW)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (ready),
    .bit_stb  (bit_stb),
    .bit_val  (bit_val),
    .my_addr  (my_addr),
    .rd_data  (rd_data),
    .reg_addr (reg_addr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe)
  );

  mdio_regfile #(.DW(DW), .PHY_ID(PHY_ID), .CAPS(CAPS)) u_regs (
    .clk            (clk),
    .rst_n          (rst_n),
    .strap_addr     (strap_addr),
    .reg_addr       (reg_addr),
    .wr_en          (wr_en),
    .wr_data        (wr_data),
    .rd_data        (rd_data),
    .my_addr        (my_addr),
    .ready          (ready),
    .stat_link      (stat_link),
    .stat_an_done   (stat_an_done),
    .stat_rem_fault (stat_rem_fault),
    .stat_jabber    (stat_jabber),
    .lp_ability     (lp_ability),
    .cnt_sel        (cnt_sel),
    .cnt_rdata      (cnt_rdata),
    .ctl_reset      (ctl_reset),
    .ctl_loopback   (ctl_loopback),
    .ctl_speed100   (ctl_speed100),
    .ctl_an_en      (ctl_an_en),
    .ctl_pwrdn      (ctl_pwrdn),
    .ctl_isolate    (ctl_isolate),
    .ctl_an_restart (ctl_an_restart),
    .ctl_fdx        (ctl_fdx)
  );

endmodule

// File: tb/mdio_mgmt_slave_bench.sv
module mdio_mgmt_slave_bench;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  strap_addr;
  logic        mdc;
  logic        mdio_i;
  logic        mdio_o;
  logic        mdio_oe;
  logic        stat_link, stat_an_done, stat_rem_fault, stat_jabber;
  logic [15:0] lp_ability;
  logic [1:0]  cnt_sel;
  logic [15:0] cnt_rdata;
  logic        ctl_reset, ctl_loopback, ctl_speed100, ctl_an_en;
  logic        ctl_pwrdn, ctl_isolate, ctl_an_restart, ctl_fdx;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  assign cnt_rdata = 16'hC000 + {14'd0, cnt_sel};

  mdio_mgmt_slave u_mdio_mgmt_slave (
    .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr), .mdc(mdc),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .stat_link(stat_link), .stat_an_done(stat_an_done),
    .stat_rem_fault(stat_rem_fault), .stat_jabber(stat_jabber),
    .lp_ability(lp_ability), .cnt_sel(cnt_sel), .cnt_rdata(cnt_rdata),
    .ctl_reset(ctl_reset), .ctl_loopback(ctl_loopback),
    .ctl_speed100(ctl_speed100), .ctl_an_en(ctl_an_en),
    .ctl_pwrdn(ctl_pwrdn), .ctl_isolate(ctl_isolate),
    .ctl_an_restart(ctl_an_restart), .ctl_fdx(ctl_fdx)
  );

  // pulse monitors
  int rst_pulses, rst_run, rst_max;
  int ran_pulses, ran_run, ran_max;
  bit prev_rst, prev_ran;
  always @(negedge clk) begin
    if (ctl_reset) begin
      rst_run++;
      if (!prev_rst) rst_pulses++;
      if (rst_run > rst_max) rst_max = rst_run;
    end else rst_run = 0;
    if (ctl_an_restart) begin
      ran_run++;
      if (!prev_ran) ran_pulses++;
      if (ran_run > ran_max) ran_max = ran_run;
    end else ran_run = 0;
    prev_rst = ctl_reset;
    prev_ran = ctl_an_restart;
  end

  task automatic clear_mon();
    rst_pulses = 0; rst_max = 0; ran_pulses = 0; ran_max = 0;
  endtask

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic send_bit(input logic b, output logic so, output logic soe);
    mdio_i = b;
    mdc    = 1'b0;
    repeat (HALF) @(negedge clk);
    so  = mdio_o;
    soe = mdio_oe;
    mdc = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic put_bit(input logic b);
    logic so, soe;
    send_bit(b, so, soe);
  endtask

  task automatic send_hdr(input int pre, input logic [1:0] op,
                          input logic [4:0] phy, input logic [4:0] ra);
    for (int i = 0; i < pre; i++) put_bit(1'b1);
    put_bit(1'b0); put_bit(1'b1);
    put_bit(op[1]); put_bit(op[0]);
    for (int i = 4; i >= 0; i--) put_bit(phy[i]);
    for (int i = 4; i >= 0; i--) put_bit(ra[i]);
  endtask

  task automatic mdio_rd(input logic [4:0] phy, input logic [4:0] ra,
                         output logic [15:0] d, output logic ok, output logic any_oe);
    logic so, soe;
    send_hdr(32, 2'b10, phy, ra);
    ok = 1'b1; any_oe = 1'b0;
    send_bit(1'b1, so, soe);
    if (soe) begin ok = 1'b0; any_oe = 1'b1; end
    send_bit(1'b1, so, soe);
    if (!soe || so) ok = 1'b0;
    if (soe) any_oe = 1'b1;
    for (int i = 15; i >= 0; i--) begin
      send_bit(1'b1, so, soe);
      d[i] = so;
      if (!soe) ok = 1'b0;
      if (soe) any_oe = 1'b1;
    end
    send_bit(1'b1, so, soe);
    if (soe) ok = 1'b0;
  endtask

  task automatic mdio_wr_x(input int pre, input logic [1:0] op, input logic [4:0] phy,
                           input logic [4:0] ra, input logic [15:0] d);
    send_hdr(pre, op, phy, ra);
    put_bit(1'b1); put_bit(1'b0);
    for (int i = 15; i >= 0; i--) put_bit(d[i]);
    put_bit(1'b1);
  endtask

  task automatic mdio_wr(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
    mdio_wr_x(32, 2'b01, phy, ra, d);
  endtask

  task automatic do_reset(input logic [4:0] strap);
    rst_n = 1'b0; strap_addr = strap; mdc = 1'b0; mdio_i = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_state();
    chk("R5 reset ctl", {8'd0, ctl_reset, ctl_loopback, ctl_speed100, ctl_an_en,
        ctl_pwrdn, ctl_isolate, ctl_an_restart, ctl_fdx}, 16'h0030);
    chk("R13 idle oe", {15'd0, mdio_oe}, 16'h0000);
  endtask

  task automatic t_strap_read();
    logic [15:0] d; logic ok, a;
    mdio_rd(5'd3, 5'd25, d, ok, a);
    chk("R3 strap reg", d, 16'h0003);
    chk("R1 R13 read framing", {15'd0, ok}, 16'h0001);
    mdio_rd(5'd0, 5'd25, d, ok, a);
    chk("R2 addr zero answered", d, 16'h0003);
    mdio_rd(5'd7, 5'd25, d, ok, a);
    chk("R2 foreign addr no drive", {15'd0, a}, 16'h0000);
  endtask

  task automatic t_adv();
    logic [15:0] d; logic ok, a;
    mdio_rd(5'd3, 5'd4, d, ok, a);
    chk("R9 adv default", d, 16'h01E1);
    mdio_wr(5'd3, 5'd4, 16'hFFFF);
    mdio_rd(5'd3, 5'd4, d, ok, a);
    chk("R9 adv reserved bits", d, 16'hE3FF);
    mdio_wr(5'd7, 5'd4, 16'h0000);
    mdio_rd(5'd3, 5'd4, d, ok, a);
    chk("R2 foreign write ignored", d, 16'hE3FF);
  endtask

  task automatic t_status();
    logic [15:0] d; logic ok, a;
    stat_link = 1'b1; stat_an_done = 1'b1; stat_rem_fault = 1'b0; stat_jabber = 1'b0;
    mdio_rd(5'd3, 5'd1, d, ok, a);
    chk("R10 status A", d, 16'h782D);
    stat_link = 1'b0; stat_an_done = 1'b0; stat_rem_fault = 1'b1; stat_jabber = 1'b1;
    mdio_rd(5'd3, 5'd1, d, ok, a);
    chk("R10 status B", d, 16'h781B);
    mdio_rd(5'd3, 5'd5, d, ok, a);
    chk("R10 partner", d, 16'h45E1);
  endtask

  task automatic t_ctrl();
    logic [15:0] d; logic ok, a;
    mdio_wr(5'd3, 5'd0, 16'h4900);
    chk("R5 ctl outputs", {8'd0, ctl_reset, ctl_loopback, ctl_speed100, ctl_an_en,
        ctl_pwrdn, ctl_isolate, ctl_an_restart, ctl_fdx}, 16'h0049);
    mdio_rd(5'd3, 5'd0, d, ok, a);
    chk("R5 ctrl readback", d, 16'h4900);
    mdio_rd(5'd3, 5'd25, d, ok, a);
    chk("R3 speed10 bit", d, 16'h0043);
  endtask

  task automatic t_restart();
    logic [15:0] d; logic ok, a;
    clear_mon();
    mdio_wr(5'd3, 5'd0, 16'h1200);
    chk("R7 restart pulses", 16'(ran_pulses), 16'd1);
    chk("R7 restart width", 16'(ran_max), 16'd1);
    mdio_rd(5'd3, 5'd0, d, ok, a);
    chk("R7 restart readback", d, 16'h1000);
  endtask

  task automatic t_soft_reset();
    logic [15:0] d; logic ok, a;
    mdio_wr(5'd3, 5'd4, 16'h0021);
    mdio_wr(5'd3, 5'd0, 16'h0100);
    clear_mon();
    mdio_wr(5'd3, 5'd0, 16'h8000);
    chk("R6 reset pulses", 16'(rst_pulses), 16'd1);
    chk("R6 reset width", 16'(rst_max), 16'd1);
    mdio_rd(5'd3, 5'd0, d, ok, a);
    chk("R6 ctrl restored", d, 16'h3000);
    mdio_rd(5'd3, 5'd4, d, ok, a);
    chk("R6 adv restored", d, 16'h01E1);
  endtask

  task automatic t_reserved();
    logic [15:0] d; logic ok, a;
    mdio_wr(5'd3, 5'd8, 16'hABCD);
    mdio_rd(5'd3, 5'd8, d, ok, a);
    chk("R8 reg8", d, 16'h0000);
    mdio_wr(5'd3, 5'd30, 16'h1234);
    mdio_rd(5'd3, 5'd30, d, ok, a);
    chk("R8 reg30", d, 16'h0000);
    mdio_wr(5'd3, 5'd25, 16'h001F);
    mdio_rd(5'd3, 5'd25, d, ok, a);
    chk("R8 reg25 read-only", d, 16'h0003);
    mdio_rd(5'd3, 5'd0, d, ok, a);
    chk("R8 ctrl untouched", d, 16'h3000);
  endtask

  task automatic t_counters();
    logic [15:0] d; logic ok, a;
    mdio_rd(5'd3, 5'd18, d, ok, a);
    chk("R11 counter 18", d, 16'hC000);
    mdio_rd(5'd3, 5'd19, d, ok, a);
    chk("R11 counter 19", d, 16'hC001);
    mdio_rd(5'd3, 5'd21, d, ok, a);
    chk("R11 counter 21", d, 16'hC002);
  endtask

  task automatic t_framing();
    logic [15:0] d; logic ok, a;
    put_bit(1'b0);
    mdio_wr_x(31, 2'b01, 5'd3, 5'd4, 16'h0000);
    put_bit(1'b0);
    mdio_wr_x(32, 2'b11, 5'd3, 5'd4, 16'h0000);
    put_bit(1'b0);
    mdio_wr_x(32, 2'b00, 5'd3, 5'd4, 16'h0000);
    put_bit(1'b0);
    mdio_rd(5'd3, 5'd4, d, ok, a);
    chk("R12 bad frames ignored", d, 16'h01E1);
  endtask

  task automatic t_strap_zero();
    logic [15:0] d; logic ok, a;
    do_reset(5'd0);
    chk("R4 isolate after zero strap", {15'd0, ctl_isolate}, 16'h0001);
    mdio_rd(5'd0, 5'd0, d, ok, a);
    chk("R4 ctrl with zero strap", d, 16'h3400);
    mdio_wr(5'd0, 5'd0, 16'h3000);
    chk("R4 isolate held", {15'd0, ctl_isolate}, 16'h0001);
    mdio_rd(5'd0, 5'd25, d, ok, a);
    chk("R3 zero strap reg", d, 16'h0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    stat_link = 1'b0; stat_an_done = 1'b0; stat_rem_fault = 1'b0; stat_jabber = 1'b0;
    lp_ability = 16'h45E1;
    clear_mon();
    do_reset(5'd3);
    t_reset_state();
    t_strap_read();
    t_adv();
    t_status();
    t_ctrl();
    t_restart();
    t_soft_reset();
    t_reserved();
    t_counters();
    t_framing();
    t_strap_zero();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule